// File: doc/BRIEF.md
# Input Frame-Rate Detector and Interpolation Path Selector

This block watches the word-select (LRCK) line of an incoming serial audio stream and works out its frame rate. It counts cycles of a fixed-frequency reference clock between successive rising edges of the synchronised LRCK, and turns each period into a rate in Hz. Rates of 32 kHz, 44.1 kHz, 48 kHz and 96 kHz all fall inside its range. A lock flag is raised once the period has held steady for a set number of frames. The flag falls on a sudden change of period, or when LRCK stops toggling.

The resampler that follows always produces a fixed 48 kHz output. The block chooses its front end from the measured rate. A slow input gets a 2x interpolation stage placed ahead of the anti-alias filter. A fast input goes straight to the anti-alias filter. The choice compares the rate with a threshold that the integrator supplies. A hysteresis band centred on that threshold stops the choice from toggling while the rate sits near it. The choice is changed only while locked, and only at an LRCK frame boundary.

Top module: `lrck_rate_selector`

## Requirements
- R1: During and right after reset, `rate_hz` is 0, `locked` is 0 and `sel_interp` is 1 (interpolate path).
- R2: Each rising edge of LRCK, apart from the first after reset or after a timeout, measures a period P. P is the number of reference cycles since the previous rising edge. `rate_hz` becomes REF_HZ / P (integer quotient). The new value appears after the third rising clock edge following the edge that first samples LRCK high.
- R3: The first LRCK rising edge after reset or after a timeout changes neither `rate_hz` nor `locked`.
- R4: `locked` becomes 1 at the update of the LOCK_N-th consecutive period where each period differs from the one before it by at most TOL cycles.
- R5: A period that differs from the one before it by more than TOL cycles clears `locked` at its own update.
- R6: If no LRCK rising edge arrives within TIMEOUT_CYC reference cycles, `locked` is cleared. `rate_hz` keeps its last value.
- R7: Let H be `hyst_hz` shifted right by one bit. At a rate update that leaves `locked` at 1, `sel_interp` becomes 0 (bypass) if `rate_hz` > `thresh_hz` + H. It becomes 1 (interpolate) if `rate_hz` + H < `thresh_hz`. The change appears one cycle after the update.
- R8: At an update whose rate lies inside the band [`thresh_hz` - H, `thresh_hz` + H], `sel_interp` keeps its value.
- R9: While `locked` is 0, `sel_interp` keeps its value.
- R10: `sel_interp` changes only in the cycle right after a rate update, that is, on an LRCK frame boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock of REF_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck_in | input | 1 | Asynchronous LRCK from the serial audio input |
| thresh_hz | input | RATE_W | Rate threshold in Hz for the path choice |
| hyst_hz | input | RATE_W | Full width of the hysteresis band in Hz |
| rate_hz | output | RATE_W | Last measured input frame rate in Hz |
| locked | output | 1 | Rate measurement is stable |
| sel_interp | output | 1 | 1: insert the 2x interpolation stage; 0: bypass it |

## Verification
A single frame update can carry two effects at once. A period that jumps far from the previous one updates `rate_hz` to a value past the threshold, and in the same cycle it clears `locked`. The path choice must then hold and must not follow the new rate. The bench provokes this by moving straight from a 96 kHz stream, which is locked on bypass, to a 32 kHz stream. It checks that `sel_interp` stays 0 over the unlocked frames and goes to 1 only at the update that relocks. A behavioural model compares all three outputs against the design on every clock.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
   typedef enum logic {
      PATH_BYPASS = 1'b0,
      PATH_INTERP = 1'b1
   } path_e;
endpackage

// File: rtl/lrs_edge_sync.sv
module lrs_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lrs_edge_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES:0] chain;

   for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
endmodule

// File: rtl/lrs_period_meter.sv
module lrs_period_meter #(
   parameter int CNT_W       = 16,
   parameter int TIMEOUT_CYC = 20000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   output logic             period_v,
   output logic [CNT_W-1:0] period,
   output logic             tout_v
);
   if (TIMEOUT_CYC < 4 || TIMEOUT_CYC >= (2 ** CNT_W)) begin : g_bad_to
      $error("lrs_period_meter: TIMEOUT_CYC must lie in [4, 2**CNT_W)");
   end

   localparam logic [CNT_W-1:0] TO_LAST = CNT_W'(TIMEOUT_CYC - 1);

   logic [CNT_W-1:0] cnt;
   logic             have_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         have_prev <= 1'b0;
         period_v  <= 1'b0;
         period    <= '0;
         tout_v    <= 1'b0;
      end else begin
         period_v <= 1'b0;
         tout_v   <= 1'b0;
         if (rise) begin
            cnt       <= '0;
            have_prev <= 1'b1;
            if (have_prev) begin
               period_v <= 1'b1;
               period   <= cnt + CNT_W'(1);
            end
         end else if (cnt == TO_LAST) begin
            cnt       <= '0;
            have_prev <= 1'b0;
            tout_v    <= 1'b1;
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/lrs_lock_tracker.sv
module lrs_lock_tracker #(
   parameter int CNT_W  = 16,
   parameter int RATE_W = 20,
   parameter int REF_HZ = 200_000_000,
   parameter int LOCK_N = 8,
   parameter int TOL    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              period_v,
   input  logic [CNT_W-1:0]  period,
   input  logic              tout_v,
   output logic [RATE_W-1:0] rate_hz,
   output logic              locked,
   output logic              upd
);
   if (LOCK_N < 2) begin : g_bad_lock
      $error("lrs_lock_tracker: LOCK_N must be at least 2");
   end
   if (CNT_W > 32 || RATE_W > 32) begin : g_bad_w
      $error("lrs_lock_tracker: CNT_W and RATE_W must not exceed 32");
   end

   localparam int               RUN_W   = $clog2(LOCK_N + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOCK_N);
   localparam logic [31:0]      REF_L   = 32'(REF_HZ);

   logic [CNT_W-1:0] ref_p;
   logic             ref_ok;
   logic [RUN_W-1:0] run;
   logic [CNT_W-1:0] absdiff;
   logic             close;
   logic [RUN_W-1:0] run_nxt;
   logic [31:0]      quo;

   always_comb begin
      absdiff = (period > ref_p) ? (period - ref_p) : (ref_p - period);
      close   = ref_ok && (absdiff <= CNT_W'(TOL));
      if (!close)              run_nxt = RUN_W'(1);
      else if (run == RUN_MAX) run_nxt = run;
      else                     run_nxt = run + RUN_W'(1);
      if (period == '0) quo = '0;
      else              quo = REF_L / {{(32-CNT_W){1'b0}}, period};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_p   <= '0;
         ref_ok  <= 1'b0;
         run     <= '0;
         rate_hz <= '0;
         locked  <= 1'b0;
         upd     <= 1'b0;
      end else begin
         upd <= 1'b0;
         if (period_v) begin
            ref_p   <= period;
            ref_ok  <= 1'b1;
            run     <= run_nxt;
            locked  <= (run_nxt >= RUN_MAX);
            rate_hz <= quo[RATE_W-1:0];
            upd     <= 1'b1;
         end else if (tout_v) begin
            ref_ok <= 1'b0;
            run    <= '0;
            locked <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/lrs_path_select.sv
module lrs_path_select
   import lrs_pkg::*;
#(
   parameter int RATE_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic              locked,
   input  logic [RATE_W-1:0] rate_hz,
   input  logic [RATE_W-1:0] thresh_hz,
   input  logic [RATE_W-1:0] hyst_hz,
   output logic              sel_interp
);
   logic [RATE_W-1:0] half;
   logic [RATE_W:0]   hi_pt;
   logic              above;
   logic              below;
   path_e             path_q;

   always_comb begin
      half  = {1'b0, hyst_hz[RATE_W-1:1]};
      hi_pt = {1'b0, thresh_hz} + {1'b0, half};
      above = {1'b0, rate_hz} > hi_pt;
      below = ({1'b0, rate_hz} + {1'b0, half}) < {1'b0, thresh_hz};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         path_q <= PATH_INTERP;
      end else if (upd && locked) begin
         if (above)      path_q <= PATH_BYPASS;
         else if (below) path_q <= PATH_INTERP;
      end
   end

   assign sel_interp = (path_q == PATH_INTERP);
endmodule

// File: rtl/lrck_rate_selector.sv
module lrck_rate_selector #(
   parameter int REF_HZ      = 200_000_000,
   parameter int CNT_W       = 16,
   parameter int RATE_W      = 20,
   parameter int LOCK_N      = 8,
   parameter int TOL         = 4,
   parameter int TIMEOUT_CYC = 20000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lrck_in,
   input  logic [RATE_W-1:0] thresh_hz,
   input  logic [RATE_W-1:0] hyst_hz,
   output logic [RATE_W-1:0] rate_hz,
   output logic              locked,
   output logic              sel_interp
);
   logic             rise;
   logic             period_v;
   logic [CNT_W-1:0] period;
   logic             tout_v;
   logic             upd;

   lrs_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(lrck_in), .rise(rise)
   );

   lrs_period_meter #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_meter (
      .clk(clk), .rst_n(rst_n), .rise(rise),
      .period_v(period_v), .period(period), .tout_v(tout_v)
   );

   lrs_lock_tracker #(
      .CNT_W(CNT_W), .RATE_W(RATE_W), .REF_HZ(REF_HZ),
      .LOCK_N(LOCK_N), .TOL(TOL)
   ) u_track (
      .clk(clk), .rst_n(rst_n), .period_v(period_v), .period(period),
      .tout_v(tout_v), .rate_hz(rate_hz), .locked(locked), .upd(upd)
   );

   lrs_path_select #(.RATE_W(RATE_W)) u_sel (
      .clk(clk), .rst_n(rst_n), .upd(upd), .locked(locked),
      .rate_hz(rate_hz), .thresh_hz(thresh_hz), .hyst_hz(hyst_hz),
      .sel_interp(sel_interp)
   );
endmodule

// File: rtl/lrck_rate_selector_chk.sv
module lrck_rate_selector_chk #(
   parameter int RATE_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              upd,
   input logic              tout_v,
   input logic              locked,
   input logic [RATE_W-1:0] rate_hz,
   input logic [RATE_W-1:0] thresh_hz,
   input logic [RATE_W-1:0] hyst_hz,
   input logic              sel_interp
);
   logic [RATE_W:0] c_half;
   logic [RATE_W:0] c_rate;
   logic [RATE_W:0] c_thr;
   always_comb begin
      c_half = {2'b00, hyst_hz[RATE_W-1:1]};
      c_rate = {1'b0, rate_hz};
      c_thr  = {1'b0, thresh_hz};
   end

   p_timeout_unlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tout_v |=> !locked);

   p_go_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && locked && (c_rate > c_thr + c_half)) |=> !sel_interp);

   p_go_interp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && locked && (c_rate + c_half < c_thr)) |=> sel_interp);

   p_band_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !(c_rate > c_thr + c_half) && !(c_rate + c_half < c_thr))
      |=> $stable(sel_interp));

   p_unlocked_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |=> $stable(sel_interp));

   p_frame_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sel_interp) |-> $past(upd));
endmodule

bind lrck_rate_selector lrck_rate_selector_chk #(.RATE_W(RATE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .upd(upd), .tout_v(tout_v), .locked(locked),
   .rate_hz(rate_hz), .thresh_hz(thresh_hz), .hyst_hz(hyst_hz),
   .sel_interp(sel_interp)
);

// File: tb/lrck_rate_selector_tb_top.sv
`timescale 1ns/1ps
module lrck_rate_selector_tb_top;
   localparam int REF_HZ  = 4_800_000;
   localparam int CNT_W   = 12;
   localparam int RATE_W  = 20;
   localparam int LOCK_N  = 4;
   localparam int TOL     = 2;
   localparam int TIMEOUT = 1000;
   localparam int THR     = 60000;
   localparam int HYS     = 1000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              lrck = 1'b0;
   logic [RATE_W-1:0] thresh_hz = RATE_W'(THR);
   logic [RATE_W-1:0] hyst_hz = RATE_W'(HYS);
   logic [RATE_W-1:0] rate_hz;
   logic              locked;
   logic              sel_interp;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   lrck_rate_selector #(
      .REF_HZ(REF_HZ), .CNT_W(CNT_W), .RATE_W(RATE_W), .LOCK_N(LOCK_N),
      .TOL(TOL), .TIMEOUT_CYC(TIMEOUT), .SYNC_STAGES(2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .lrck_in(lrck), .thresh_hz(thresh_hz),
      .hyst_hz(hyst_hz), .rate_hz(rate_hz), .locked(locked),
      .sel_interp(sel_interp)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model, advanced on every rising clock edge
   int  k = 0;
   bit  h1, h2, h3;
   int  last_ev = 0;
   bit  have_prev;
   bit  pp_v, pt_v;
   int  pp;
   int  run, refp;
   bit  ref_ok;
   int  m_rate;
   bit  m_lock, m_upd;
   bit  m_sel = 1'b1;

   always @(posedge clk) begin
      bit rise_now;
      k++;
      if (!rst_n) begin
         h1 = 0; h2 = 0; h3 = 0; last_ev = k; have_prev = 0;
         pp_v = 0; pt_v = 0; run = 0; ref_ok = 0; refp = 0;
         m_rate = 0; m_lock = 0; m_upd = 0; m_sel = 1;
      end else begin
         if (m_upd && m_lock) begin
            if (m_rate > THR + HYS / 2)      m_sel = 0;
            else if (m_rate + HYS / 2 < THR) m_sel = 1;
         end
         m_upd = 0;
         if (pp_v) begin
            if (ref_ok && ((pp > refp ? pp - refp : refp - pp) <= TOL))
               run = (run >= LOCK_N) ? LOCK_N : run + 1;
            else
               run = 1;
            refp = pp; ref_ok = 1;
            m_lock = (run >= LOCK_N);
            m_rate = REF_HZ / pp;
            m_upd = 1;
         end else if (pt_v) begin
            run = 0; ref_ok = 0; m_lock = 0;
         end
         pp_v = 0; pt_v = 0;
         rise_now = h2 && !h3;
         if (rise_now) begin
            if (have_prev) begin pp_v = 1; pp = k - last_ev; end
            have_prev = 1; last_ev = k;
         end else if (k - 1 - last_ev == TIMEOUT - 1) begin
            pt_v = 1; have_prev = 0; last_ev = k;
         end
         h3 = h2; h2 = h1; h1 = lrck;
      end
   end

   // compare against the model every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 rate_hz vs model", int'(rate_hz), m_rate);
         chk("R4 locked vs model", int'(locked), int'(m_lock));
         chk("R10 sel_interp vs model", int'(sel_interp), int'(m_sel));
      end
   end

   task automatic frames(input int hi, input int lo, input int n);
      for (int i = 0; i < n; i++) begin
         lrck = 1'b1;
         repeat (hi) @(negedge clk);
         lrck = 1'b0;
         repeat (lo) @(negedge clk);
      end
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R1 reset rate", int'(rate_hz), 0);
      chk("R1 reset locked", int'(locked), 0);
      chk("R1 reset sel", int'(sel_interp), 1);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R1 idle sel", int'(sel_interp), 1);

      // 48 kHz: period 100
      frames(50, 50, 8);
      chk("R2 rate 48k", int'(rate_hz), 48000);
      chk("R4 locked 48k", int'(locked), 1);
      chk("R7 interp below band", int'(sel_interp), 1);

      // 96 kHz: period 50, above band -> bypass
      frames(25, 25, 8);
      chk("R2 rate 96k", int'(rate_hz), 96000);
      chk("R7 bypass above band", int'(sel_interp), 0);

      // jump to 32 kHz: deviation drops lock, select holds
      frames(75, 75, 3);
      chk("R5 lock lost on jump", int'(locked), 0);
      chk("R2 rate 32k", int'(rate_hz), 32000);
      chk("R9 hold while unlocked", int'(sel_interp), 0);
      frames(75, 75, 4);
      chk("R4 relocked 32k", int'(locked), 1);
      chk("R7 interp at 32k", int'(sel_interp), 1);

      // 44.1 kHz nominal: period 109
      frames(55, 54, 8);
      chk("R2 rate 44.1k", int'(rate_hz), 44036);
      chk("R7 interp at 44.1k", int'(sel_interp), 1);

      // hysteresis walk around 60 kHz threshold
      frames(41, 40, 8);
      chk("R7 interp 59259", int'(sel_interp), 1);
      frames(40, 40, 8);
      chk("R2 rate in band", int'(rate_hz), 60000);
      chk("R8 hold interp in band", int'(sel_interp), 1);
      frames(40, 39, 8);
      chk("R7 bypass 60759", int'(sel_interp), 0);
      frames(40, 40, 8);
      chk("R8 hold bypass in band", int'(sel_interp), 0);
      frames(41, 40, 8);
      chk("R7 back to interp", int'(sel_interp), 1);

      // LRCK stops: timeout clears lock, rate retained
      repeat (1200) @(negedge clk);
      chk("R6 timeout unlock", int'(locked), 0);
      chk("R6 rate retained", int'(rate_hz), 59259);

      // first edge after timeout gives no update
      frames(50, 50, 1);
      chk("R3 no update first edge", int'(rate_hz), 59259);
      chk("R3 still unlocked", int'(locked), 0);
      frames(50, 50, 8);
      chk("R4 relock 48k", int'(locked), 1);
      chk("R2 rate back to 48k", int'(rate_hz), 48000);
      chk("R10 sel after relock", int'(sel_interp), 1);

      repeat (10) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule